// File: doc/BRIEF.md
# SDRAM Start-up and Command-Gap Sequencer

This block brings an SDRAM device from power-up to an operational state, then spaces the few commands whose minimum separation it owns. Software places a start-up wait count and a packed timing byte on the configuration inputs and raises the enable input. The block drives idle cycles while the wait count runs out. It then issues a precharge of every bank, one auto-refresh and a mode-register load, and finally raises a ready flag.

Once ready, the block accepts row-open, row-close and refresh requests from an upstream arbiter, one command per cycle. A request whose minimum gap since the related earlier command has not yet elapsed is held with a busy flag and is issued on the first cycle the gap allows. Each gap is taken from the timing byte at the moment the earlier command is issued. Dropping enable returns the block to idle, and the whole start-up sequence runs again on the next enable.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the command bus shows NOP, A10 is low, and ready and busy are both low.
- R2: With start-up count D, the edge that first samples enable high is followed by exactly D+1 NOP cycles, and then the precharge-all command appears.
- R3: Precharge-all drives A10 high. Auto-refresh follows in the very next cycle. The mode-register load follows the refresh after exactly RC NOP cycles, where RC is timing-byte bits 5:3.
- R4: Ready goes high exactly MRD cycles after the cycle showing the mode-register load, or in that same cycle when MRD is 0, where MRD is timing-byte bits 7:6. A row-open request seen in the first ready cycle is issued in the next cycle.
- R5: Requests raised before ready are ignored. No row-open, row-close or refresh command is issued for them during start-up.
- R6: Command codes on {cs_n, ras_n, cas_n, we_n} are: NOP 0111, row-open 0011, precharge 0010, refresh 0001, mode-register load 0000.
- R7: A held row-close request is issued exactly RP+1 cycles after the row-open, where RP is timing-byte bits 2:0. Busy is high while it waits, and A10 is low on a run-time precharge.
- R8: A held row-open request is issued exactly RC+1 cycles after a run-time refresh.
- R9: When requests coincide, refresh wins over row-close, and row-close wins over row-open. The losing request stays pending and no second command is issued.
- R10: One cycle after enable goes low, the bus shows NOP and ready is low. The next enable restarts the full start-up sequence, including the wait count.
- R11: A gap uses the timing-byte value present when the earlier command was issued. Later changes to the byte do not shorten it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sequencer enable |
| init_dly | input | 14 | Start-up wait count in clock cycles |
| tim_ctrl | input | 8 | Packed gaps: [7:6] load-to-open, [5:3] refresh-to-open, [2:0] open-to-close |
| req_act | input | 1 | Row-open request |
| req_pre | input | 1 | Row-close request |
| req_ref | input | 1 | Refresh request |
| ready | output | 1 | Start-up done, requests accepted |
| busy | output | 1 | Selected request held by a gap |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10 (all-bank flag on precharge) |

## Verification
Two functions can meet in one cycle: a new refresh request, and a row-open request that is being held by the refresh-to-open gap. The bench holds a row-open request until busy rises, then raises refresh in the same cycle. It expects the refresh on the bus, with the row-open still pending. It then expects the row-open only after a full fresh gap counted from the new refresh, even though the timing byte is cleared right after that refresh. A refresh and a row-close request raised together are judged the same way.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   // bus encoding {cs_n, ras_n, cas_n, we_n}
   typedef enum logic [3:0] {
      CMD_LMR = 4'b0000,
      CMD_REF = 4'b0001,
      CMD_PRE = 4'b0010,
      CMD_ACT = 4'b0011,
      CMD_NOP = 4'b0111
   } sdram_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WAIT,
      ST_AREF,
      ST_RGAP,
      ST_MGAP,
      ST_RUN
   } seq_state_e;

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
   parameter int WIDTH = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [WIDTH-1:0] load_val,
   output logic             expired
);

   if (WIDTH < 1) begin : g_bad_width
      $error("sdram_gap_timer: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr)            cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   AST_TIMER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !load && !expired) |=> (cnt_q == WIDTH'($past(cnt_q) - 1'b1))); // R2

   AST_TIMER_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !clr) |=> (cnt_q == $past(load_val))); // R11

endmodule

// File: rtl/sdram_cmd_reg.sv
module sdram_cmd_reg
   import sdram_seq_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  sdram_cmd_e cmd_d,
   input  logic       a10_d,
   output sdram_cmd_e cmd_q,
   output logic       a10_q
);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmd_q <= CMD_NOP;
            a10_q <= 1'b0;
         end else begin
            cmd_q <= cmd_d;
            a10_q <= a10_d;
         end
      end
   end else begin : g_comb
      assign cmd_q = cmd_d;
      assign a10_q = a10_d;
   end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
   import sdram_seq_pkg::*;
#(
   parameter int INIT_W = 14,
   parameter int MRD_W  = 2,
   parameter int RC_W   = 3,
   parameter int RP_W   = 3,
   parameter int CTRL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [INIT_W-1:0] init_dly,
   input  logic [CTRL_W-1:0] tim_ctrl,
   input  logic              req_act,
   input  logic              req_pre,
   input  logic              req_ref,
   output logic              ready,
   output logic              busy,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic              a10
);

   localparam int SEQ_W  = (MRD_W > RC_W) ? MRD_W : RC_W;
   localparam int CHK_W  = RC_W + 1;

   if (MRD_W + RC_W + RP_W != CTRL_W) begin : g_bad_pack
      $error("sdram_cmd_seq: timing fields must fill the control byte");
   end

   // field extraction: open-to-close low, refresh-to-open middle, load-to-open top
   logic [MRD_W-1:0] f_mrd;
   logic [RC_W-1:0]  f_rc;
   logic [RP_W-1:0]  f_rp;
   assign f_mrd = tim_ctrl[CTRL_W-1 -: MRD_W];
   assign f_rc  = tim_ctrl[RP_W +: RC_W];
   assign f_rp  = tim_ctrl[0 +: RP_W];

   seq_state_e       st_q, st_nx;
   sdram_cmd_e       nx_cmd, cmd_q;
   logic             nx_a10, a10_q;
   logic             init_ld, seq_ld, rc_ld, rp_ld;
   logic [SEQ_W-1:0] seq_val;
   logic             init_exp, seq_exp, rc_exp, rp_exp;
   logic             rdy, busy_c;

   sdram_gap_timer #(.WIDTH(INIT_W)) u_init_tmr (
      .clk(clk), .rst_n(rst_n), .clr(!en), .load(init_ld),
      .load_val(init_dly), .expired(init_exp));

   sdram_gap_timer #(.WIDTH(SEQ_W)) u_seq_tmr (
      .clk(clk), .rst_n(rst_n), .clr(!en), .load(seq_ld),
      .load_val(seq_val), .expired(seq_exp));

   sdram_gap_timer #(.WIDTH(RC_W)) u_rc_tmr (
      .clk(clk), .rst_n(rst_n), .clr(!en), .load(rc_ld),
      .load_val(f_rc), .expired(rc_exp));

   sdram_gap_timer #(.WIDTH(RP_W)) u_rp_tmr (
      .clk(clk), .rst_n(rst_n), .clr(!en), .load(rp_ld),
      .load_val(f_rp), .expired(rp_exp));

   always_comb begin
      st_nx   = st_q;
      nx_cmd  = CMD_NOP;
      nx_a10  = 1'b0;
      init_ld = 1'b0;
      seq_ld  = 1'b0;
      seq_val = '0;
      rc_ld   = 1'b0;
      rp_ld   = 1'b0;
      busy_c  = 1'b0;
      rdy     = en && ((st_q == ST_RUN) || ((st_q == ST_MGAP) && seq_exp));

      case (st_q)
         ST_IDLE: begin
            if (en) begin
               st_nx   = ST_WAIT;
               init_ld = 1'b1;
            end
         end
         ST_WAIT: begin
            if (init_exp) begin
               nx_cmd = CMD_PRE;
               nx_a10 = 1'b1;
               st_nx  = ST_AREF;
            end
         end
         ST_AREF: begin
            nx_cmd  = CMD_REF;
            seq_ld  = 1'b1;
            seq_val = SEQ_W'(f_rc);
            st_nx   = ST_RGAP;
         end
         ST_RGAP: begin
            if (seq_exp) begin
               nx_cmd  = CMD_LMR;
               seq_ld  = 1'b1;
               seq_val = SEQ_W'(f_mrd);
               st_nx   = ST_MGAP;
            end
         end
         default: ;
      endcase

      if (rdy) begin
         st_nx = ST_RUN;
         if (req_ref) begin
            nx_cmd = CMD_REF;
            rc_ld  = 1'b1;
         end else if (req_pre) begin
            if (rp_exp) nx_cmd = CMD_PRE;
            else        busy_c = 1'b1;
         end else if (req_act) begin
            if (rc_exp) begin
               nx_cmd = CMD_ACT;
               rp_ld  = 1'b1;
            end else begin
               busy_c = 1'b1;
            end
         end
      end

      if (!en) begin
         st_nx   = ST_IDLE;
         nx_cmd  = CMD_NOP;
         nx_a10  = 1'b0;
         init_ld = 1'b0;
         seq_ld  = 1'b0;
         rc_ld   = 1'b0;
         rp_ld   = 1'b0;
         busy_c  = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_nx;
   end

   sdram_cmd_reg #(.REG_OUT(1'b1)) u_cmd_reg (
      .clk(clk), .rst_n(rst_n), .cmd_d(nx_cmd), .a10_d(nx_a10),
      .cmd_q(cmd_q), .a10_q(a10_q));

   assign {cs_n, ras_n, cas_n, we_n} = cmd_q;
   assign a10   = a10_q;
   assign ready = rdy;
   assign busy  = busy_c;

   // checker: cycles since the last run-time refresh and the gap it captured
   logic [CHK_W-1:0] chk_since;
   logic [RC_W-1:0]  chk_gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_since <= '1;
         chk_gap   <= '0;
      end else if (rc_ld) begin
         chk_since <= '0;
         chk_gap   <= f_rc;
      end else if (chk_since != '1) begin
         chk_since <= chk_since + 1'b1;
      end
   end

   AST_REF_TO_ACT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_ACT) |-> (chk_since > CHK_W'(chk_gap))); // R8

   AST_ACT_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q == CMD_ACT) |-> $past(ready)); // R5

   AST_BUSY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP)); // R7

   AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (({cs_n, ras_n, cas_n, we_n} == CMD_NOP) && !ready)); // R10

   AST_INIT_PRE_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_AREF) |-> ((cmd_q == CMD_PRE) && a10)); // R3

   AST_WAIT_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_WAIT) |-> (cmd_q == CMD_NOP)); // R2

endmodule

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;

   localparam logic [3:0] C_NOP = 4'b0111;
   localparam logic [3:0] C_ACT = 4'b0011;
   localparam logic [3:0] C_PRE = 4'b0010;
   localparam logic [3:0] C_REF = 4'b0001;
   localparam logic [3:0] C_LMR = 4'b0000;

   // {init delay, mrd, rc, rp}
   localparam int NVEC = 4;
   localparam logic [21:0] VEC [NVEC] = '{
      {14'd0,  2'd0, 3'd0, 3'd0},
      {14'd5,  2'd3, 3'd7, 3'd7},
      {14'd3,  2'd1, 3'd2, 3'd5},
      {14'd20, 2'd2, 3'd4, 3'd1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [13:0] init_dly = '0;
   logic [7:0]  tim_ctrl = '0;
   logic        req_act = 1'b0, req_pre = 1'b0, req_ref = 1'b0;
   logic        ready, busy, cs_n, ras_n, cas_n, we_n, a10;
   logic [3:0]  cmd_w;

   int nchk = 0;
   int nerr = 0;

   always #5 clk = ~clk;

   sdram_cmd_seq u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .init_dly(init_dly), .tim_ctrl(tim_ctrl),
      .req_act(req_act), .req_pre(req_pre), .req_ref(req_ref),
      .ready(ready), .busy(busy), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .a10(a10));

   assign cmd_w = {cs_n, ras_n, cas_n, we_n};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // returns the first non-NOP command and how many negedges it took
   task automatic wait_cmd(output logic [3:0] c, output int n);
      c = C_NOP;
      n = -1;
      for (int i = 1; i <= 80; i++) begin
         @(negedge clk);
         if (cmd_w != C_NOP) begin
            c = cmd_w;
            n = i;
            break;
         end
      end
   endtask

   task automatic wait_ready(output int k);
      k = 0;
      while (!ready && k < 40) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic restart(input logic [13:0] d, input logic [7:0] t);
      @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk(cmd_w == C_NOP, "R10 bus idle after disable", int'(cmd_w), int'(C_NOP));
      chk(ready == 1'b0, "R10 ready low after disable", int'(ready), 0);
      init_dly = d;
      tim_ctrl = t;
      en = 1'b1;
   endtask

   task automatic bring_up(input logic [13:0] d, input logic [7:0] t);
      logic [3:0] c;
      int n;
      restart(d, t);
      wait_cmd(c, n);
      wait_cmd(c, n);
      wait_cmd(c, n);
      wait_ready(n);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      logic [3:0] c;
      int n;
      int k;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(cmd_w == C_NOP, "R1 bus NOP in reset", int'(cmd_w), int'(C_NOP));
      chk(!ready && !busy && !a10, "R1 flags low in reset", int'({ready, busy, a10}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_w == C_NOP && !ready, "R1 idle after reset", int'(cmd_w), int'(C_NOP));

      // table walk over timing configurations
      for (int v = 0; v < NVEC; v++) begin
         logic [13:0] d;
         logic [1:0]  mrd;
         logic [2:0]  rc, rp;
         {d, mrd, rc, rp} = VEC[v];
         restart(d, {mrd, rc, rp});
         wait_cmd(c, n);
         chk(c == C_PRE, "R2 first command is precharge", int'(c), int'(C_PRE));
         chk(n == int'(d) + 2, "R2 start-up wait length", n, int'(d) + 2);
         chk(a10 == 1'b1, "R3 precharge-all A10 high", int'(a10), 1);
         wait_cmd(c, n);
         chk(c == C_REF && n == 1, "R3 refresh right after precharge", int'(c) * 100 + n, int'(C_REF) * 100 + 1);
         wait_cmd(c, n);
         chk(c == C_LMR, "R6 mode load code", int'(c), int'(C_LMR));
         chk(n == int'(rc) + 1, "R3 refresh to mode load gap", n, int'(rc) + 1);
         wait_ready(k);
         chk(k == int'(mrd), "R4 mode load to ready", k, int'(mrd));
         req_act = 1'b1;
         wait_cmd(c, n);
         chk(c == C_ACT && n == 1, "R4 first row-open", int'(c) * 100 + n, int'(C_ACT) * 100 + 1);
         req_act = 1'b0;
         req_pre = 1'b1;
         #1;
         chk(busy == (rp != 3'd0), "R7 busy while close waits", int'(busy), int'(rp != 3'd0));
         wait_cmd(c, n);
         req_pre = 1'b0;
         chk(c == C_PRE && n == int'(rp) + 1, "R7 open to close gap", int'(c) * 100 + n, int'(C_PRE) * 100 + int'(rp) + 1);
         chk(a10 == 1'b0, "R7 run-time precharge A10 low", int'(a10), 0);
         req_ref = 1'b1;
         wait_cmd(c, n);
         req_ref = 1'b0;
         chk(c == C_REF && n == 1, "R6 run-time refresh", int'(c) * 100 + n, int'(C_REF) * 100 + 1);
         req_act = 1'b1;
         wait_cmd(c, n);
         req_act = 1'b0;
         chk(c == C_ACT && n == int'(rc) + 1, "R8 refresh to open gap", int'(c) * 100 + n, int'(C_ACT) * 100 + int'(rc) + 1);
      end

      // R5: requests during start-up are ignored
      restart(14'd10, 8'h00);
      req_act = 1'b1;
      req_ref = 1'b1;
      wait_cmd(c, n);
      req_ref = 1'b0;
      chk(c == C_PRE && n == 12, "R5 no early command", int'(c) * 100 + n, int'(C_PRE) * 100 + 12);
      wait_cmd(c, n);
      wait_cmd(c, n);
      chk(c == C_LMR, "R5 sequence not disturbed", int'(c), int'(C_LMR));
      wait_cmd(c, n);
      req_act = 1'b0;
      chk(c == C_ACT && n == 1, "R5 held open issued once ready", int'(c) * 100 + n, int'(C_ACT) * 100 + 1);

      // R9 / R11: coincident requests and captured gap
      bring_up(14'd0, {2'd0, 3'd3, 3'd0});
      req_ref = 1'b1;
      wait_cmd(c, n);
      req_ref = 1'b0;
      req_act = 1'b1;
      @(negedge clk);
      chk(busy == 1'b1 && cmd_w == C_NOP, "R8 open held after refresh", int'(busy), 1);
      req_ref = 1'b1;
      req_pre = 1'b1;
      wait_cmd(c, n);
      chk(c == C_REF && n == 1, "R9 refresh beats close and open", int'(c) * 100 + n, int'(C_REF) * 100 + 1);
      req_ref = 1'b0;
      req_pre = 1'b0;
      tim_ctrl = 8'h00;
      wait_cmd(c, n);
      req_act = 1'b0;
      chk(c == C_ACT && n == 4, "R11 gap kept from issue time", int'(c) * 100 + n, int'(C_ACT) * 100 + 4);

      // R10: disable mid start-up restarts everything
      restart(14'd4, 8'h00);
      repeat (3) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk(cmd_w == C_NOP && !ready, "R10 quiet mid start-up", int'(cmd_w), int'(C_NOP));
      en = 1'b1;
      wait_cmd(c, n);
      chk(c == C_PRE && n == 6, "R10 full wait after re-enable", int'(c) * 100 + n, int'(C_PRE) * 100 + 6);

      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

endmodule